// File: doc/BRIEF.md
# Multiprocessor-Wakeup UART Receiver

This block receives asynchronous serial characters from a multi-drop line shared by several processors. The line is sampled with a 16x oversampling tick from an external baud generator. A character is a low start bit, 7 or 8 data bits sent least significant bit first, an optional address-marker bit, and one stop bit. The received byte, the marker bit, a data-full flag and two error flags (overrun, framing) are presented to the host.

Multiprocessor format adds the marker bit after the data bits. An address byte has the marker set to 1. When the wake-up filter is on, the receiver discards every character whose marker is 0. A node can therefore sleep through traffic meant for other nodes and wake only on address bytes. A discarded character changes no flag and no data output. The host pulses a read strobe to consume a byte and a separate error-reset strobe to clear the error flags. The receiver can be switched off by its enable input or by a stop-mode input. Switching it off abandons the character being shifted in and leaves the flags as they were.

Top module: `mpu_wake_rx`

## Requirements
- R1: A character is a low start bit, then data bits LSB first (8 bits when `len8`=1, 7 bits when `len8`=0), then the marker bit only when `mp_fmt`=1, then one stop bit. An accepted character loads `rx_data` and sets `data_full`. With 7 data bits, `rx_data[7]` reads 0.
- R2: A falling edge on the line starts a character only if the line is still low half a bit time (8 ticks) later. A shorter low pulse is ignored. Later bits are sampled 16 ticks apart, at their midpoints.
- R3: With `mp_fmt`=1 and `wake_en`=1, a character whose marker bit is 0 is discarded. `data_full`, `overrun`, `frame_err` and `rx_data` stay unchanged, even when its stop bit is low. A character whose marker bit is 1 is accepted.
- R4: With `mp_fmt`=1 and `wake_en`=0, every character is accepted and `rx_mpb` shows its marker bit.
- R5: With `mp_fmt`=0, `wake_en` has no effect, every character is accepted and `rx_mpb` reads 0.
- R6: The receiver is active only while `rx_en`=1 and `stop_mode`=0. Dropping either condition abandons a character in progress. It also holds `data_full`, `overrun`, `frame_err` and `rx_data` at their previous values.
- R7: An accepted character that completes while `data_full` is 1 sets `overrun` and leaves `rx_data` holding the older byte.
- R8: An accepted character whose stop bit samples low sets `frame_err`.
- R9: A one-cycle `rd_stb` clears `data_full` only. A one-cycle `err_clr` clears `overrun` and `frame_err` only.
- R10: Asynchronous reset (`rst_n`=0) and synchronous reset (`sync_rst`=1) both clear all flags and `rx_data`, and return the receiver to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_rst | input | 1 | Synchronous reset of receiver and flags |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| stop_mode | input | 1 | Low-power stop; forces the receiver off |
| mp_fmt | input | 1 | Selects multiprocessor format (marker bit present) |
| wake_en | input | 1 | Wake-up filter enable |
| len8 | input | 1 | 1: eight data bits, 0: seven |
| rd_stb | input | 1 | Host read strobe, clears data-full |
| err_clr | input | 1 | Error-reset strobe, clears overrun and framing error |
| rx_data | output | 8 | Last accepted byte |
| rx_mpb | output | 1 | Marker bit of the last accepted byte |
| data_full | output | 1 | Unread byte present |
| overrun | output | 1 | A character arrived while a byte was unread |
| frame_err | output | 1 | Stop bit sampled low |

## Verification
The bench uses the default parameters: 16x oversampling and a two-stage line synchronizer. The tick arrives every fourth clock, so a bit lasts 64 clocks. Because the tick is slower than the clock, the bench can show that the counters advance only on the tick. It can also hold a glitch of four ticks, which is shorter than the 8-tick start qualification, and show that it is rejected. With these values both data lengths and every combination of format and wake-up setting are reachable in a short run. So is a receiver switched off in the middle of a character.

// File: rtl/mpwr_pkg.sv
package mpwr_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_MARK  = 3'd3,
    RX_STOP  = 3'd4,
    RX_WAITH = 3'd5
  } rx_state_e;
endpackage

// File: rtl/mpwr_sync.sv
module mpwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/mpwr_shifter.sv
module mpwr_shifter
  import mpwr_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              line,
  input  logic              mp_fmt,
  input  logic              len8,
  output logic              done,
  output logic [DATA_W-1:0] byte_o,
  output logic              mpb_o,
  output logic              stop_ok
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int IW   = $clog2(DATA_W);

  rx_state_e         st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [IW-1:0]     idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              mpb_q, mpb_n;
  logic              done_q, done_n;
  logic              stop_q, stop_n;
  logic [IW-1:0]     last_idx;
  logic              bit_end;

  assign last_idx = len8 ? IW'(DATA_W - 1) : IW'(DATA_W - 2);
  assign bit_end  = (cnt_q == CW'(OVS - 1));

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    mpb_n  = mpb_q;
    stop_n = stop_q;
    done_n = 1'b0;
    if (!en) begin
      st_n  = RX_IDLE;
      cnt_n = '0;
    end else if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!line) begin
            st_n  = RX_START;
            cnt_n = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_n = '0;
            idx_n = '0;
            st_n  = line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt_n = '0;
            sh_n  = {line, sh_q[DATA_W-1:1]};
            if (idx_q == last_idx) begin
              st_n  = mp_fmt ? RX_MARK : RX_STOP;
              mpb_n = 1'b0;
            end else begin
              idx_n = idx_q + 1'b1;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_MARK: begin
          if (bit_end) begin
            cnt_n = '0;
            mpb_n = line;
            st_n  = RX_STOP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_end) begin
            cnt_n  = '0;
            stop_n = line;
            done_n = 1'b1;
            st_n   = line ? RX_IDLE : RX_WAITH;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_WAITH: begin
          if (line) st_n = RX_IDLE;
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      mpb_q  <= 1'b0;
      done_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      mpb_q  <= mpb_n;
      done_q <= done_n;
      stop_q <= stop_n;
    end
  end

  assign done    = done_q;
  assign mpb_o   = mpb_q;
  assign stop_ok = stop_q;
  assign byte_o  = len8 ? sh_q : {1'b0, sh_q[DATA_W-1:1]};

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_q == RX_IDLE) && !done_q) else $error("abort"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done pulse"); // R1
  AST_NO_MARK_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !mp_fmt && $past(!mp_fmt)) |-> !mpb_q) else $error("mark"); // R5
endmodule

// File: rtl/mpwr_flags.sv
module mpwr_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              done,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              mpb_i,
  input  logic              stop_ok,
  input  logic              mp_fmt,
  input  logic              wake_en,
  input  logic              rd_stb,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              data_full,
  output logic              overrun,
  output logic              frame_err
);
  logic [DATA_W-1:0] data_q, data_n;
  logic              mpb_q, mpb_n;
  logic              df_q, df_n, ov_q, ov_n, fe_q, fe_n;
  logic              accept, load, ovr_set;

  assign accept  = done && (!(mp_fmt && wake_en) || mpb_i);
  assign load    = accept && !df_q;
  assign ovr_set = accept && df_q;

  always_comb begin
    data_n = data_q;
    mpb_n  = mpb_q;
    df_n   = load | ovr_set | (df_q & ~rd_stb);
    ov_n   = ovr_set | (ov_q & ~err_clr);
    fe_n   = (accept & ~stop_ok) | (fe_q & ~err_clr);
    if (load) begin
      data_n = byte_i;
      mpb_n  = mpb_i;
    end
    if (srst) begin
      data_n = '0;
      mpb_n  = 1'b0;
      df_n   = 1'b0;
      ov_n   = 1'b0;
      fe_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mpb_q  <= 1'b0;
      df_q   <= 1'b0;
      ov_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      data_q <= data_n;
      mpb_q  <= mpb_n;
      df_q   <= df_n;
      ov_q   <= ov_n;
      fe_q   <= fe_n;
    end
  end

  assign rx_data   = data_q;
  assign rx_mpb    = mpb_q;
  assign data_full = df_q;
  assign overrun   = ov_q;
  assign frame_err = fe_q;

  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mp_fmt && wake_en && !mpb_i && !rd_stb && !err_clr && !srst)
    |=> $stable(df_q) && $stable(ov_q) && $stable(fe_q) && $stable(data_q))
    else $error("drop"); // R3
  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && df_q && !srst && (!(mp_fmt && wake_en) || mpb_i))
    |=> ov_q && $stable(data_q)) else $error("overrun"); // R7
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !done && !srst) |=> !df_q) else $error("read"); // R9
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !df_q && !ov_q && !fe_q) else $error("srst"); // R10
endmodule

// File: rtl/mpu_wake_rx.sv
module mpu_wake_rx #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_rst,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       stop_mode,
  input  logic       mp_fmt,
  input  logic       wake_en,
  input  logic       len8,
  input  logic       rd_stb,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       rx_mpb,
  output logic       data_full,
  output logic       overrun,
  output logic       frame_err
);
  localparam int DATA_W = 8;

  logic              line_s;
  logic              rx_act;
  logic              f_done, f_mpb, f_stop;
  logic [DATA_W-1:0] f_byte;

  assign rx_act = rx_en && !stop_mode && !sync_rst;

  mpwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rxd), .d_out(line_s)
  );

  mpwr_shifter #(.OVS(OVS), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(rx_act), .tick(tick16), .line(line_s),
    .mp_fmt(mp_fmt), .len8(len8), .done(f_done), .byte_o(f_byte),
    .mpb_o(f_mpb), .stop_ok(f_stop)
  );

  mpwr_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .srst(sync_rst), .done(f_done),
    .byte_i(f_byte), .mpb_i(f_mpb), .stop_ok(f_stop), .mp_fmt(mp_fmt),
    .wake_en(wake_en), .rd_stb(rd_stb), .err_clr(err_clr),
    .rx_data(rx_data), .rx_mpb(rx_mpb), .data_full(data_full),
    .overrun(overrun), .frame_err(frame_err)
  );

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && $past(!rx_en) && !rd_stb && !err_clr && !sync_rst)
    |=> $stable(data_full) && $stable(overrun) && $stable(frame_err))
    else $error("off"); // R6
endmodule

// File: tb/test_mpu_wake_rx.sv
`timescale 1ns/1ps
module test_mpu_wake_rx;
  localparam int BITCLK = 64;

  logic clk = 1'b0;
  logic rst_n, sync_rst, tick16, rxd, rx_en, stop_mode;
  logic mp_fmt, wake_en, len8, rd_stb, err_clr;
  logic [7:0] rx_data;
  logic rx_mpb, data_full, overrun, frame_err;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mpu_wake_rx i_mpu_wake_rx (
    .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst), .tick16(tick16),
    .rxd(rxd), .rx_en(rx_en), .stop_mode(stop_mode), .mp_fmt(mp_fmt),
    .wake_en(wake_en), .len8(len8), .rd_stb(rd_stb), .err_clr(err_clr),
    .rx_data(rx_data), .rx_mpb(rx_mpb), .data_full(data_full),
    .overrun(overrun), .frame_err(frame_err)
  );

  initial begin
    tick16 = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic v);
    rxd = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic m, input logic stp);
    put_bit(1'b0);
    for (int i = 0; i < (len8 ? 8 : 7); i++) put_bit(d[i]);
    if (mp_fmt) put_bit(m);
    put_bit(stp);
    put_bit(1'b1);
    put_bit(1'b1);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 df", data_full, 0);
    chk("R10 ov", overrun, 0);
    chk("R10 fe", frame_err, 0);
    chk("R10 data", rx_data, 0);
  endtask

  task automatic t_basic();
    mp_fmt = 0; len8 = 1;
    send(8'hA5, 0, 1);
    chk("R1 df", data_full, 1);
    chk("R1 data", rx_data, 8'hA5);
    chk("R1 fe", frame_err, 0);
    pulse(rd_stb);
    chk("R9 rd clears df", data_full, 0);
    chk("R9 data kept", rx_data, 8'hA5);
  endtask

  task automatic t_len7();
    len8 = 0;
    send(8'hD3, 0, 1);
    chk("R1 7bit data", rx_data, 8'h53);
    pulse(rd_stb);
    len8 = 1;
  endtask

  task automatic t_wake();
    mp_fmt = 1; wake_en = 1;
    send(8'h11, 0, 1);
    chk("R3 dropped df", data_full, 0);
    chk("R3 dropped data", rx_data, 8'h53);
    send(8'h19, 0, 0);
    chk("R3 dropped bad stop fe", frame_err, 0);
    send(8'h22, 1, 1);
    chk("R3 address df", data_full, 1);
    chk("R3 address data", rx_data, 8'h22);
    chk("R3 address mpb", rx_mpb, 1);
    pulse(rd_stb);
  endtask

  task automatic t_nowake();
    mp_fmt = 1; wake_en = 0;
    send(8'h33, 0, 1);
    chk("R4 df", data_full, 1);
    chk("R4 data", rx_data, 8'h33);
    chk("R4 mpb", rx_mpb, 0);
    pulse(rd_stb);
  endtask

  task automatic t_plain_wake();
    mp_fmt = 0; wake_en = 1;
    send(8'h44, 0, 1);
    chk("R5 df", data_full, 1);
    chk("R5 data", rx_data, 8'h44);
    chk("R5 mpb", rx_mpb, 0);
    pulse(rd_stb);
    wake_en = 0;
  endtask

  task automatic t_overrun();
    send(8'h55, 0, 1);
    send(8'h66, 0, 1);
    chk("R7 ov", overrun, 1);
    chk("R7 data kept", rx_data, 8'h55);
    pulse(err_clr);
    chk("R9 err_clr ov", overrun, 0);
    chk("R9 err_clr keeps df", data_full, 1);
    pulse(rd_stb);
  endtask

  task automatic t_frame();
    send(8'h77, 0, 0);
    chk("R8 fe", frame_err, 1);
    chk("R8 data", rx_data, 8'h77);
    pulse(rd_stb);
    chk("R9 rd keeps fe", frame_err, 1);
    pulse(err_clr);
    chk("R9 err_clr fe", frame_err, 0);
  endtask

  task automatic t_glitch();
    rxd = 0;
    repeat (16) @(negedge clk);
    rxd = 1;
    repeat (BITCLK * 12) @(negedge clk);
    chk("R2 glitch ignored", data_full, 0);
    send(8'h3C, 0, 1);
    chk("R2 after glitch data", rx_data, 8'h3C);
    pulse(rd_stb);
  endtask

  task automatic t_abort();
    send(8'h12, 0, 1);
    put_bit(1'b0);
    for (int i = 0; i < 4; i++) put_bit(i[0]);
    rx_en = 0;
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    put_bit(1'b1);
    put_bit(1'b1);
    rx_en = 1;
    repeat (BITCLK * 2) @(negedge clk);
    chk("R6 df held", data_full, 1);
    chk("R6 data held", rx_data, 8'h12);
    pulse(rd_stb);
    stop_mode = 1;
    send(8'h56, 0, 1);
    chk("R6 stop ignored", data_full, 0);
    stop_mode = 0;
    send(8'h78, 0, 1);
    chk("R6 resumes", rx_data, 8'h78);
  endtask

  task automatic t_srst();
    send(8'h9A, 0, 0);
    chk("R10 pre fe", frame_err, 1);
    pulse(sync_rst);
    chk("R10 srst df", data_full, 0);
    chk("R10 srst ov", overrun, 0);
    chk("R10 srst fe", frame_err, 0);
    chk("R10 srst data", rx_data, 0);
  endtask

  initial begin
    rst_n = 0; sync_rst = 0; rxd = 1; rx_en = 0; stop_mode = 0;
    mp_fmt = 0; wake_en = 0; len8 = 1; rd_stb = 0; err_clr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    rx_en = 1;
    repeat (BITCLK) @(negedge clk);
    t_basic();
    t_len7();
    t_wake();
    t_nowake();
    t_plain_wake();
    t_overrun();
    t_frame();
    t_glitch();
    t_abort();
    t_srst();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule